// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a 32-bit virtual address into a 32-bit physical address by looking up one entry of a flat, single-level page table kept in main memory. Software loads two context registers through a small write port whenever the running process changes. One register holds the physical address of entry zero. The other holds how many entries the table has.

A request carries a virtual address and a flag that marks it as a write. The unit takes the page number from the upper 20 bits of the address. It rejects the page at once if the page lies beyond the table. Otherwise it reads the 4-byte entry over a request/acknowledge memory port and checks the entry's valid and read-only flags. It answers with a one-cycle completion pulse that carries either the physical address or a fault code. If the access succeeds and the entry's use or modified flag must be set, the unit writes the entry back to memory before it signals completion.

Top module: `vpt_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `rsp_done`, `mem_req` and `rsp_exc` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge through the cycle of the completion pulse, and returns to 1 in the cycle after it. `mem_req` is never 1 while `req_ready` is 1.
- R3: A page number (address bits [31:12]) that is greater than or equal to the length register completes with code 1, one cycle after acceptance, and performs no memory access. A length of 0 rejects every page.
- R4: For an in-range page, the unit issues a read (`mem_we`=0) at address base + 4 × page. It holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack`. `mem_ack` is 1 for exactly one cycle and, on a read, carries `mem_rdata`.
- R5: On success `rsp_exc` is 0, and `rsp_paddr` is the entry's bits [31:12] followed by the unchanged virtual bits [11:0]. For example, page 2 mapped to frame 0x50000 turns 0x00002004 into 0x50000004.
- R6: An entry whose bit 0 (valid) is 0 completes with code 2 and leaves memory untouched.
- R7: A write to an entry whose bit 1 (read-only) is 1 completes with code 3 and leaves memory untouched. A read of the same entry succeeds.
- R8: A successful access sets bit 2 (use) of the entry. A successful write also sets bit 3 (modified). All other entry bits are written back unchanged, to the same address.
- R9: A write-back happens only when bit 2 or bit 3 actually changes. `rsp_done` rises in the cycle after the last `mem_ack` of the request.
- R10: `rsp_done` is a single-cycle pulse. When it carries a nonzero code, `rsp_paddr` is 0.
- R11: A configuration write with `cfg_sel`=0 loads the base register, and with `cfg_sel`=1 loads the length register. Both reset to 0, and the new value governs the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Context register write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfg_wdata | input | 32 | Context register write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 32 | Translated physical address, valid with rsp_done |
| rsp_exc | output | 2 | Fault code: 0 none, 1 out of range, 2 invalid, 3 protection |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Entry physical address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |

## Verification
Each result has a fixed due cycle once the memory latency L is known. A range fault completes one cycle after acceptance. For an in-range page, the entry fetch holds `mem_req` for L+1 cycles and any write-back holds it for another L+1 cycles. The completion pulse then follows one cycle after the last acknowledge. The bench predicts these windows from the page, the entry flags and L, and compares `mem_req`, the address, the direction, the write data, `rsp_done` and `req_ready` at every falling edge against that prediction. It also reads the modelled memory after each request to confirm the stored flags.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned PA_W  = 32;
  localparam int unsigned OFS_W = 12;
  localparam int unsigned PTE_W = 32;

  // entry flag positions (decoded by software and by this unit alike)
  localparam int unsigned PTE_VALID = 0;
  localparam int unsigned PTE_RO    = 1;
  localparam int unsigned PTE_USE   = 2;
  localparam int unsigned PTE_MOD   = 3;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_RANGE   = 2'd1,
    EXC_INVALID = 2'd2,
    EXC_PROT    = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WBACK = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/vpt_ctx_regs.sv
module vpt_ctx_regs #(
  parameter int unsigned PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic [PA_W-1:0] tbl_base,
  output logic [PA_W-1:0] tbl_len
);
  logic            base_en;
  logic            len_en;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] len_q;

  always_comb begin
    base_en = cfg_we && !cfg_sel;
    len_en  = cfg_we &&  cfg_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= cfg_wdata;
    end
  end

  assign tbl_base = base_q;
  assign tbl_len  = len_q;
endmodule

// File: rtl/vpt_pte_eval.sv
module vpt_pte_eval
  import vpt_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                  is_write,
  input  logic [PTE_W-1:0]      pte,
  output exc_e                  fault,
  output logic [PTE_W-1:0]      pte_upd,
  output logic                  need_wb,
  output logic [PA_W-OFS_W-1:0] frame
);
  localparam int unsigned FRM_W = PA_W - OFS_W;

  always_comb begin
    pte_upd = pte;
    fault   = EXC_NONE;
    if (!pte[PTE_VALID]) begin
      fault = EXC_INVALID;
    end else if (is_write && pte[PTE_RO]) begin
      fault = EXC_PROT;
    end else begin
      pte_upd[PTE_USE] = 1'b1;
      if (is_write) begin
        pte_upd[PTE_MOD] = 1'b1;
      end
    end
  end

  assign need_wb = (fault == EXC_NONE) && (pte_upd != pte);
  assign frame   = pte[PTE_W-1 -: FRM_W];
endmodule

// File: rtl/vpt_walk_fsm.sv
module vpt_walk_fsm
  import vpt_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  output logic                  req_ready,
  input  logic [PA_W-1:0]       tbl_base,
  input  logic [PA_W-1:0]       tbl_len,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output logic [PTE_W-1:0]      mem_wdata,
  input  logic                  mem_ack,
  output logic                  ev_write,
  input  exc_e                  ev_fault,
  input  logic [PTE_W-1:0]      ev_pte_upd,
  input  logic                  ev_need_wb,
  input  logic [PA_W-OFS_W-1:0] ev_frame,
  output logic                  rsp_done,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_exc
);
  localparam int unsigned PN_W   = VA_W - OFS_W;
  localparam int unsigned FRM_W  = PA_W - OFS_W;
  localparam int unsigned ENT_SH = $clog2(PTE_W / 8);

  walk_st_e               st_q, st_d;
  logic [OFS_W-1:0]       ofs_q, ofs_d;
  logic                   wr_q, wr_d;
  logic [PA_W-1:0]        addr_q, addr_d;
  logic [PTE_W-1:0]       wdat_q, wdat_d;
  exc_e                   exc_q, exc_d;
  logic [FRM_W-1:0]       frm_q, frm_d;

  logic [PN_W-1:0]        page;
  logic [PA_W-1:0]        page_ext;
  logic [PA_W-1:0]        ent_addr;
  logic                   in_range;

  always_comb begin
    page     = req_vaddr[VA_W-1:OFS_W];
    page_ext = PA_W'(page);
    ent_addr = tbl_base + (page_ext << ENT_SH);
    in_range = page_ext < tbl_len;
  end

  always_comb begin
    st_d   = st_q;
    ofs_d  = ofs_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    exc_d  = exc_q;
    frm_d  = frm_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ofs_d = req_vaddr[OFS_W-1:0];
          wr_d  = req_write;
          frm_d = '0;
          if (in_range) begin
            addr_d = ent_addr;
            exc_d  = EXC_NONE;
            st_d   = ST_FETCH;
          end else begin
            exc_d = EXC_RANGE;
            st_d  = ST_DONE;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          exc_d  = ev_fault;
          frm_d  = ev_frame;
          wdat_d = ev_pte_upd;
          if (ev_need_wb) begin
            st_d = ST_WBACK;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ofs_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      exc_q  <= EXC_NONE;
      frm_q  <= '0;
    end else begin
      st_q   <= st_d;
      ofs_q  <= ofs_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      exc_q  <= exc_d;
      frm_q  <= frm_d;
    end
  end

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    mem_req   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
    mem_we    = (st_q == ST_WBACK);
    mem_addr  = addr_q;
    mem_wdata = wdat_q;
    ev_write  = wr_q;
    rsp_done  = (st_q == ST_DONE);
    rsp_exc   = exc_q;
    rsp_paddr = (exc_q == EXC_NONE) ? {frm_q, ofs_q} : '0;
  end
endmodule

// File: rtl/vpt_xlate.sv
module vpt_xlate
  import vpt_pkg::*;
#(
  parameter int unsigned VA_W  = vpt_pkg::VA_W,
  parameter int unsigned PA_W  = vpt_pkg::PA_W,
  parameter int unsigned OFS_W = vpt_pkg::OFS_W,
  parameter int unsigned PTE_W = vpt_pkg::PTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_done,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_exc,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  localparam int unsigned FRM_W = PA_W - OFS_W;

  logic [PA_W-1:0]  tbl_base;
  logic [PA_W-1:0]  tbl_len;
  logic             ev_write;
  exc_e             ev_fault;
  logic [PTE_W-1:0] ev_pte_upd;
  logic             ev_need_wb;
  logic [FRM_W-1:0] ev_frame;

  vpt_ctx_regs #(.PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_base  (tbl_base),
    .tbl_len   (tbl_len)
  );

  vpt_pte_eval #(.PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)) u_eval (
    .is_write (ev_write),
    .pte      (mem_rdata),
    .fault    (ev_fault),
    .pte_upd  (ev_pte_upd),
    .need_wb  (ev_need_wb),
    .frame    (ev_frame)
  );

  vpt_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .tbl_base   (tbl_base),
    .tbl_len    (tbl_len),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .ev_write   (ev_write),
    .ev_fault   (ev_fault),
    .ev_pte_upd (ev_pte_upd),
    .ev_need_wb (ev_need_wb),
    .ev_frame   (ev_frame),
    .rsp_done   (rsp_done),
    .rsp_paddr  (rsp_paddr),
    .rsp_exc    (rsp_exc)
  );
endmodule

// File: rtl/vpt_xlate_chk.sv
module vpt_xlate_chk #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_exc,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PA_W-1:0]  mem_addr,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             mem_ack
);
  // R2: completion never overlaps the idle indication
  a_r2_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  // R2: no memory traffic while idle
  a_r2_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10: faulting responses carry a zero address
  a_r10_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_exc != 2'd0) |-> (rsp_paddr == '0));

  // R3: a range fault completes right after acceptance
  a_r3_range_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_exc == 2'd1) |-> $past(req_valid && req_ready));

  // R4: the memory request is held steady until acknowledged
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8: every write-back carries the use flag
  a_r8_wb_use_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[2]);

  // R9: completion follows an acknowledge or the acceptance edge
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(mem_ack) || $past(req_valid && req_ready)));
endmodule

bind vpt_xlate vpt_xlate_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/vpt_xlate_bench.sv
`timescale 1ns/1ps
module vpt_xlate_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        rsp_done;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_exc;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wcnt = 0;
  logic [31:0] mem [64];

  vpt_xlate u_vpt_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_done(rsp_done), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memory: acknowledges after mem_lat waiting cycles
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt >= mem_lat) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:2]];
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request, compared every cycle against the predicted schedule
  task automatic do_req(input logic [31:0] va, input bit wr, input int lat,
                        input logic [1:0] e_exc, input logic [31:0] e_pa,
                        input bit e_fetch, input logic [31:0] e_ent,
                        input bit e_wb, input logic [31:0] e_new,
                        input logic [31:0] e_mem, input string tag);
    int nd;
    bit trace_ok;
    logic [31:0] bad;
    mem_lat = lat;
    nd = 1 + (e_fetch ? lat + 1 : 0) + (e_wb ? lat + 1 : 0);
    trace_ok = 1'b1;
    bad = '0;
    @(negedge clk);
    check(req_ready === 1'b1, {tag, " R2 ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= nd; n++) begin
      bit in_f;
      bit in_w;
      in_f = e_fetch && (n <= lat + 1);
      in_w = e_wb && (n >= lat + 2) && (n <= 2 * lat + 2);
      if (mem_req !== (in_f || in_w)) begin trace_ok = 1'b0; bad = 32'(n); end
      if (in_f && (mem_addr !== e_ent || mem_we !== 1'b0)) begin trace_ok = 1'b0; bad = mem_addr; end
      if (in_w && (mem_addr !== e_ent || mem_we !== 1'b1 || mem_wdata !== e_new)) begin
        trace_ok = 1'b0; bad = mem_wdata;
      end
      if (req_ready !== 1'b0) begin trace_ok = 1'b0; bad = 32'(n); end
      if (rsp_done !== (n == nd)) begin trace_ok = 1'b0; bad = 32'(n); end
      if (n == nd) begin
        check(rsp_exc === e_exc, {tag, " R3/R6/R7 code"}, 32'(rsp_exc), 32'(e_exc));
        check(rsp_paddr === e_pa, {tag, " R5 R10 address"}, rsp_paddr, e_pa);
      end
      @(negedge clk);
    end
    check(trace_ok, {tag, " R4 R9 cycle schedule"}, bad, e_new);
    check(rsp_done === 1'b0 && req_ready === 1'b1, {tag, " R10 R2 after pulse"},
          {30'd0, rsp_done, req_ready}, 32'd1);
    if (e_fetch)
      check(mem[e_ent[7:2]] === e_mem, {tag, " R8 stored entry"}, mem[e_ent[7:2]], e_mem);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // context A: base 0x40, 4 entries
    mem[16] = 32'h5000_2005;  // valid, use already set
    mem[17] = 32'h5000_1001;  // valid
    mem[18] = 32'h5000_0003;  // valid, read-only
    mem[19] = 32'h6000_2000;  // invalid
    // context B: base 0x80, 3 entries
    mem[32] = 32'h4000_100D;  // valid, use, modified
    mem[33] = 32'h7900_5001;  // valid
    mem[34] = 32'h7FAD_D001;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && rsp_done === 1'b0 && mem_req === 1'b0 && rsp_exc === 2'd0,
          "R1 reset state", {28'd0, req_ready, rsp_done, mem_req, |rsp_exc}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_done === 1'b0 && mem_req === 1'b0,
          "R1 after release", {29'd0, req_ready, rsp_done, mem_req}, 32'h4);

    // R11: base and length start at zero, so page 0 is out of range
    do_req(32'h0000_0123, 1'b0, 0, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, "R11 R3 zero length");
    cfg_write(1'b0, 32'h0000_0040);
    cfg_write(1'b1, 32'h0000_0004);

    do_req(32'h0000_0123, 1'b0, 0, 2'd0, 32'h5000_2123, 1'b1, 32'h40, 1'b0, 32'h0,
           32'h5000_2005, "R5 R9 read no change");
    do_req(32'h0000_1ABC, 1'b0, 2, 2'd0, 32'h5000_1ABC, 1'b1, 32'h44, 1'b1, 32'h5000_1005,
           32'h5000_1005, "R8 use set");
    do_req(32'h0000_1000, 1'b0, 1, 2'd0, 32'h5000_1000, 1'b1, 32'h44, 1'b0, 32'h0,
           32'h5000_1005, "R9 second read");
    do_req(32'h0000_2004, 1'b1, 1, 2'd3, 32'h0, 1'b1, 32'h48, 1'b0, 32'h0,
           32'h5000_0003, "R7 write read-only");
    do_req(32'h0000_2004, 1'b0, 0, 2'd0, 32'h5000_0004, 1'b1, 32'h48, 1'b1, 32'h5000_0007,
           32'h5000_0007, "R7 R5 read read-only");
    do_req(32'h0000_31A4, 1'b1, 0, 2'd2, 32'h0, 1'b1, 32'h4C, 1'b0, 32'h0,
           32'h6000_2000, "R6 invalid entry");
    do_req(32'h0000_4000, 1'b0, 0, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, "R3 page equals length");
    do_req(32'hFFFF_FFFF, 1'b1, 0, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, "R3 top page");

    cfg_write(1'b0, 32'h0000_0080);
    cfg_write(1'b1, 32'h0000_0003);
    do_req(32'h0000_0010, 1'b1, 0, 2'd0, 32'h4000_1010, 1'b1, 32'h80, 1'b0, 32'h0,
           32'h4000_100D, "R11 R9 write no change");
    do_req(32'h0000_1FFF, 1'b1, 1, 2'd0, 32'h7900_5FFF, 1'b1, 32'h84, 1'b1, 32'h7900_500D,
           32'h7900_500D, "R8 modified set");
    do_req(32'h0000_2ABC, 1'b0, 3, 2'd0, 32'h7FAD_DABC, 1'b1, 32'h88, 1'b1, 32'h7FAD_D005,
           32'h7FAD_D005, "R4 long latency");
    do_req(32'h0000_3000, 1'b0, 0, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, "R3 new length");
    cfg_write(1'b1, 32'h0000_0000);
    do_req(32'h0000_0000, 1'b0, 0, 2'd1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, "R3 R11 length zero");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule